// File: doc/BRIEF.md
# Priority-Preemptive Flit Interleaver

This block schedules the transmit side of a serial fabric link. Four virtual-lane sources each offer packets as streams of flits, one flit per handshake, with start and end markers. The block merges them onto a single output flit stream. Each output flit is tagged with the lane it came from, so the far end can rebuild every packet.

Lanes have fixed strict priority: lane 3 highest, lane 0 lowest. With preemption enabled, a lower-priority packet that is part way out can be suspended at a flit boundary when a higher lane offers a flit. Once the higher packet has finished, the suspended one continues with its next flit. Suspensions may nest, and packets resume from the highest suspended lane downwards. With preemption disabled, every packet goes out whole, and packets start in the order their first flits were offered. The forwarding path is combinational from the chosen lane to the output. The only state is one open-packet bit per lane, an arrival-age matrix and a stall lock. The mode bit may be changed only while no packet is partly sent.

Top module: `vl_flit_interleaver`

## Requirements
- R1: After reset, with no lane offering a flit, `out_valid` is low and every bit of `in_ready` is low.
- R2: A forwarded flit keeps its data and its start/end markers unchanged. `out_lane` carries the source lane as a binary index, 0 to 3.
- R3: At most one bit of `in_ready` is high in any cycle. It is high only for the lane being forwarded, and only while `out_ready` is high.
- R4: While `out_valid` is high and `out_ready` is low, the next cycle presents the same flit from the same lane.
- R5: With `preempt_en` high and no stall held from the previous cycle, the forwarded lane is the highest-numbered lane that either offers a flit or has a packet partly sent. No lower lane is forwarded while a higher lane offers a flit.
- R6: A suspended packet resumes with the flit that follows its last sent flit. That flit carries no start marker.
- R7: Nested suspensions resume strictly from the highest suspended lane downwards.
- R8: With `preempt_en` low, once a packet's first flit is accepted, only that lane is forwarded until its end-marked flit is accepted.
- R9: With `preempt_en` low, a waiting packet starts in the order its first flit was offered. Packets first offered in the same cycle start higher lane first.
- R10: On every lane, flits leave in the order they entered, with none lost and none duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| preempt_en | input | 1 | 1: mid-packet preemption allowed; 0: whole packets in arrival order |
| in_valid | input | LANES | Per-lane flit offered |
| in_ready | output | LANES | Per-lane flit taken |
| in_data | input | LANES*FW | Per-lane flit payload, lane l at bits [l*FW +: FW] |
| in_sof | input | LANES | Per-lane first-flit marker |
| in_eof | input | LANES | Per-lane last-flit marker |
| out_valid | output | 1 | Output flit present |
| out_ready | input | 1 | Link accepts the output flit |
| out_data | output | FW | Output flit payload |
| out_lane | output | $clog2(LANES) | Source lane tag |
| out_sof | output | 1 | Output first-flit marker |
| out_eof | output | 1 | Output last-flit marker |

## Verification
A stale open-packet bit shows up in the same cycle at the output. A lane that should have finished keeps priority and blocks lower lanes, or a lane that is actually open is skipped and its flits land inside another packet. A corrupted arrival-age entry swaps the start order of two waiting packets in whole-packet mode, and it shows on the first flit after the current packet ends. A stall lock that fails to hold makes the output flit change under backpressure one cycle after the stall begins.

// File: rtl/vl_ilv_pkg.sv
// Shared helpers for the flit interleaver.
package vl_ilv_pkg;

    // Index of the most significant set bit of v (0 when v is zero).
    function automatic int top_index(input logic [31:0] v);
        int r;
        r = 0;
        for (int k = 0; k < 32; k++) begin
            if (v[k]) r = k;
        end
        return r;
    endfunction

endpackage

// File: rtl/vl_lane_track.sv
// Per-lane open-packet tracker.
// Holds one bit per lane that is set while that lane has sent at least one
// flit of a packet but not yet its end-marked flit.
// Assumes sources mark the last flit of every packet.
module vl_lane_track #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preempt_en,
    input  logic [LANES-1:0] fire,
    input  logic [LANES-1:0] eof,
    output logic [LANES-1:0] active
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic open_q;
        // Open on any accepted non-final flit, close on the accepted final flit.
        always_ff @(posedge clk) begin
            if (!rst_n)       open_q <= 1'b0;
            else if (fire[l]) open_q <= ~eof[l];
        end
        assign active[l] = open_q;
    end

    // Whole-packet mode never has two packets open at once.
    p_single_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !preempt_en |-> $countones(active) <= 1);

endmodule

// File: rtl/vl_arrival_order.sv
// Arrival-age tracker for lanes waiting to start a packet.
// A lane is pending while it offers a flit and has no packet open. Row i of
// the age matrix marks the lanes that became pending before lane i. Lanes
// that become pending in the same cycle are ordered higher lane first.
// Assumes a source holds its offer until it is accepted.
module vl_arrival_order #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pend,
    input  logic [LANES-1:0] fire,
    output logic [LANES-1:0] oldest
);

    logic [LANES-1:0] seen_q;
    logic [LANES-1:0] ahead_q  [LANES];
    logic [LANES-1:0] ahead_eff[LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_row
        // Effective age row: stored for known lanes, rebuilt for new arrivals.
        always_comb begin
            for (int j = 0; j < LANES; j++) begin
                if (j == i)         ahead_eff[i][j] = 1'b0;
                else if (seen_q[i]) ahead_eff[i][j] = ahead_q[i][j] & seen_q[j];
                else                ahead_eff[i][j] = seen_q[j] | (j > i);
            end
        end
        assign oldest[i] = pend[i] & ~|(ahead_eff[i] & pend);
    end

    // Store the age rows and which lanes were already waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            for (int i = 0; i < LANES; i++) ahead_q[i] <= '0;
        end else begin
            seen_q <= pend & ~fire;
            for (int i = 0; i < LANES; i++) ahead_q[i] <= ahead_eff[i];
        end
    end

    p_oldest_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oldest));
    p_oldest_exists_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (|oldest));

endmodule

// File: rtl/vl_lane_pick.sv
// Lane selector.
// Preemptive mode: highest lane that offers a flit or has a packet open.
// Whole-packet mode: the open lane if any, otherwise the oldest waiting lane.
// A held stall overrides both so the output stays stable under backpressure.
module vl_lane_pick #(
    parameter int LANES = 4
) (
    input  logic                     preempt_en,
    input  logic [LANES-1:0]         in_valid,
    input  logic [LANES-1:0]         active,
    input  logic [LANES-1:0]         oldest,
    input  logic                     hold,
    input  logic [$clog2(LANES)-1:0] hold_lane,
    output logic [$clog2(LANES)-1:0] sel,
    output logic                     have
);
    import vl_ilv_pkg::*;

    localparam int LW = $clog2(LANES);

    logic [LANES-1:0] cand;

    // Choose the lane to forward this cycle.
    always_comb begin
        cand = in_valid | active;
        sel  = '0;
        have = 1'b0;
        if (hold) begin
            sel  = hold_lane;
            have = 1'b1;
        end else if (preempt_en) begin
            have = |cand;
            sel  = LW'(top_index(32'(cand)));
        end else if (|active) begin
            have = 1'b1;
            sel  = LW'(top_index(32'(active)));
        end else if (|oldest) begin
            have = 1'b1;
            sel  = LW'(top_index(32'(oldest)));
        end
    end

endmodule

// File: rtl/vl_flit_interleaver.sv
// Priority-preemptive flit interleaver, top level.
// Merges LANES valid/ready flit streams onto one tagged output stream.
// The selected lane is forwarded combinationally. A one-cycle stall lock
// keeps a refused flit in place until the link takes it.
// Assumes: sources hold an offered flit stable until accepted; preempt_en
// changes only while no packet is partly sent; lane LANES-1 is highest.
module vl_flit_interleaver #(
    parameter int LANES = 4,
    parameter int FW    = 65
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preempt_en,
    input  logic [LANES-1:0]         in_valid,
    output logic [LANES-1:0]         in_ready,
    input  logic [LANES*FW-1:0]      in_data,
    input  logic [LANES-1:0]         in_sof,
    input  logic [LANES-1:0]         in_eof,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [FW-1:0]            out_data,
    output logic [$clog2(LANES)-1:0] out_lane,
    output logic                     out_sof,
    output logic                     out_eof
);

    localparam int LW = $clog2(LANES);

    logic [LANES-1:0] active, oldest, pend, fire;
    logic [LW-1:0]    sel, hold_lane_q;
    logic             have, hold_q;

    assign pend = in_valid & ~active;
    assign fire = in_valid & in_ready;

    vl_lane_track #(.LANES(LANES)) u_track (
        .clk(clk), .rst_n(rst_n), .preempt_en(preempt_en),
        .fire(fire), .eof(in_eof), .active(active)
    );

    vl_arrival_order #(.LANES(LANES)) u_order (
        .clk(clk), .rst_n(rst_n), .pend(pend), .fire(fire), .oldest(oldest)
    );

    vl_lane_pick #(.LANES(LANES)) u_pick (
        .preempt_en(preempt_en), .in_valid(in_valid), .active(active),
        .oldest(oldest), .hold(hold_q), .hold_lane(hold_lane_q),
        .sel(sel), .have(have)
    );

    // Forward the selected lane's flit with its tag.
    assign out_valid = have & in_valid[sel];
    assign out_data  = in_data[sel*FW +: FW];
    assign out_sof   = in_sof[sel];
    assign out_eof   = in_eof[sel];
    assign out_lane  = sel;

    // Grant the selected lane only when the link can take its flit.
    always_comb begin
        in_ready = '0;
        if (have && out_ready) in_ready[sel] = 1'b1;
    end

    // Lock the selection while an offered flit is refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= 1'b0;
            hold_lane_q <= '0;
        end else begin
            hold_q      <= out_valid & ~out_ready;
            hold_lane_q <= sel;
        end
    end

    p_ready_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_lane) && $stable(out_data)));
    p_top_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preempt_en && out_valid && !hold_q) |-> (((in_valid >> out_lane) >> 1) == '0));
    p_no_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!preempt_en && out_valid && out_ready && !out_eof) |=>
        (!out_valid || out_lane == $past(out_lane)));

endmodule

// File: tb/vl_flit_interleaver_bench.sv
module vl_flit_interleaver_bench;

    localparam int LANES = 4;
    localparam int FW    = 65;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                preempt_en = 1'b1;
    logic [LANES-1:0]    in_valid = '0, in_sof = '0, in_eof = '0;
    logic [LANES-1:0]    in_ready;
    logic [LANES*FW-1:0] in_data = '0;
    logic                out_valid, out_sof, out_eof;
    logic                out_ready = 1'b0;
    logic [FW-1:0]       out_data;
    logic [1:0]          out_lane;

    always #5 clk = ~clk;

    vl_flit_interleaver #(.LANES(LANES), .FW(FW)) u_vl_flit_interleaver (
        .clk(clk), .rst_n(rst_n), .preempt_en(preempt_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_lane(out_lane),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit gaps = 0;

    // Sources: per-lane flit queues with a release cycle per flit.
    int sq_seq[LANES][$];
    bit sq_sof[LANES][$];
    bit sq_eof[LANES][$];
    int sq_rel[LANES][$];
    int gen_seq[LANES];
    bit vis[LANES];

    // Reference model state.
    bit m_act[LANES];
    int m_q[$];
    bit m_hold = 0;
    int m_hold_lane = 0;
    int exp_seq[LANES];
    bit prev_stall = 0;
    int prev_lane = 0;
    logic [FW-1:0] prev_data = '0;

    // Accepted-flit log for directed sequences.
    int log_lane[$];
    int log_seq[$];
    bit log_sof[$];

    function automatic logic [FW-1:0] mk(int l, int s);
        logic [FW-1:0] d;
        d = '0;
        d[15:0]  = s[15:0];
        d[17:16] = l[1:0];
        return d;
    endfunction

    task automatic chk(bit ok, string tag, string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    task automatic add_pkt(int l, int len, int rel);
        for (int k = 0; k < len; k++) begin
            sq_seq[l].push_back(gen_seq[l]);
            gen_seq[l]++;
            sq_sof[l].push_back(k == 0);
            sq_eof[l].push_back(k == len - 1);
            sq_rel[l].push_back(rel);
        end
    endtask

    function automatic bit in_mq(int l);
        foreach (m_q[k]) if (m_q[k] == l) return 1;
        return 0;
    endfunction

    function automatic bit idle();
        for (int l = 0; l < LANES; l++)
            if (sq_seq[l].size() != 0 || m_act[l] || vis[l]) return 0;
        return 1;
    endfunction

    // One clock: drive at the falling edge, compare against the model, advance it.
    task automatic step();
        bit m_have, exp_v;
        int m_sel, hi;
        logic [LANES-1:0] exp_rdy;
        @(negedge clk);
        cyc++;
        for (int l = 0; l < LANES; l++) begin
            if (!vis[l] && sq_seq[l].size() > 0 && sq_rel[l][0] <= cyc &&
                (!gaps || ($urandom % 3) != 0))
                vis[l] = 1;
            in_valid[l] = vis[l];
            in_data[l*FW +: FW] = vis[l] ? mk(l, sq_seq[l][0]) : '0;
            in_sof[l] = vis[l] ? sq_sof[l][0] : 1'b0;
            in_eof[l] = vis[l] ? sq_eof[l][0] : 1'b0;
        end
        out_ready = gaps ? (($urandom % 4) != 0) : 1'b1;
        #1;
        for (int l = LANES - 1; l >= 0; l--)
            if (vis[l] && !m_act[l] && !in_mq(l)) m_q.push_back(l);
        m_have = 0;
        m_sel  = 0;
        if (m_hold) begin
            m_have = 1; m_sel = m_hold_lane;
        end else if (preempt_en) begin
            for (int l = 0; l < LANES; l++)
                if (m_act[l] || vis[l]) begin m_have = 1; m_sel = l; end
        end else begin
            for (int l = 0; l < LANES; l++)
                if (m_act[l]) begin m_have = 1; m_sel = l; end
            if (!m_have && m_q.size() > 0) begin m_have = 1; m_sel = m_q[0]; end
        end
        exp_v = m_have && vis[m_sel];
        chk(out_valid == exp_v, preempt_en ? "R5" : "R8",
            $sformatf("out_valid act=%0b exp=%0b cyc=%0d", out_valid, exp_v, cyc));
        if (exp_v && out_valid) begin
            chk(int'(out_lane) == m_sel, preempt_en ? "R5" : "R9",
                $sformatf("lane act=%0d exp=%0d cyc=%0d", out_lane, m_sel, cyc));
            chk(out_data == mk(m_sel, sq_seq[m_sel][0]) && out_sof == sq_sof[m_sel][0] &&
                out_eof == sq_eof[m_sel][0], "R2",
                $sformatf("flit act=%h/%0b%0b exp=%h/%0b%0b", out_data, out_sof, out_eof,
                          mk(m_sel, sq_seq[m_sel][0]), sq_sof[m_sel][0], sq_eof[m_sel][0]));
        end
        exp_rdy = '0;
        if (m_have && out_ready) exp_rdy[m_sel] = 1'b1;
        chk(in_ready == exp_rdy, "R3",
            $sformatf("in_ready act=%b exp=%b cyc=%0d", in_ready, exp_rdy, cyc));
        if (prev_stall)
            chk(out_valid && int'(out_lane) == prev_lane && out_data == prev_data, "R4",
                $sformatf("stalled flit act=%0d/%h exp=%0d/%h", out_lane, out_data,
                          prev_lane, prev_data));
        if (preempt_en && out_valid && !prev_stall) begin
            hi = 0;
            for (int l = int'(out_lane) + 1; l < LANES; l++) if (vis[l]) hi = 1;
            chk(hi == 0, "R5", $sformatf("higher lane waiting behind lane %0d act=1 exp=0", out_lane));
        end
        prev_stall = out_valid && !out_ready;
        prev_lane  = int'(out_lane);
        prev_data  = out_data;
        if (exp_v && out_ready) begin
            chk(int'(out_data[15:0]) == exp_seq[m_sel] && int'(out_data[17:16]) == m_sel, "R10",
                $sformatf("lane %0d seq act=%0d exp=%0d", m_sel, out_data[15:0], exp_seq[m_sel]));
            exp_seq[m_sel]++;
            log_lane.push_back(m_sel);
            log_seq.push_back(sq_seq[m_sel][0]);
            log_sof.push_back(sq_sof[m_sel][0]);
            m_act[m_sel] = !sq_eof[m_sel][0];
            foreach (m_q[k]) if (m_q[k] == m_sel) begin m_q.delete(k); break; end
            void'(sq_seq[m_sel].pop_front());
            void'(sq_sof[m_sel].pop_front());
            void'(sq_eof[m_sel].pop_front());
            void'(sq_rel[m_sel].pop_front());
            vis[m_sel] = 0;
        end
        m_hold      = exp_v && !out_ready;
        m_hold_lane = m_sel;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (!idle() && n < 20000) begin step(); n++; end
        chk(idle(), "R10", $sformatf("traffic drained act=%0b exp=1", idle()));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int exp_a[$];
        int exp_b[$];
        int s0, base;
        exp_a = '{0,0,1,3,3,1,1,1,0,0,0,0};
        exp_b = '{0,0,0,2,2,1,1,3,3};
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk(out_valid == 1'b0, "R1", $sformatf("out_valid act=%0b exp=0", out_valid));
        chk(in_ready == '0, "R1", $sformatf("in_ready act=%b exp=0000", in_ready));

        // R6 / R7: nested preemption and resume order
        preempt_en = 1'b1;
        gaps = 0;
        s0 = gen_seq[0];
        base = cyc + 1;
        add_pkt(0, 6, base);
        add_pkt(1, 4, base + 2);
        add_pkt(3, 2, base + 3);
        log_lane.delete(); log_seq.delete(); log_sof.delete();
        repeat (14) step();
        chk(log_lane.size() == 12, "R7", $sformatf("nested flit count act=%0d exp=12", log_lane.size()));
        for (int k = 0; k < 12; k++)
            if (k < log_lane.size())
                chk(log_lane[k] == exp_a[k], "R7",
                    $sformatf("nested slot %0d lane act=%0d exp=%0d", k, log_lane[k], exp_a[k]));
        if (log_lane.size() > 8)
            chk(log_sof[8] == 0 && log_seq[8] == s0 + 2, "R6",
                $sformatf("resumed flit seq/sof act=%0d/%0b exp=%0d/0", log_seq[8], log_sof[8], s0 + 2));

        // R8 / R9: whole-packet mode, arrival order with a same-cycle tie
        preempt_en = 1'b0;
        base = cyc + 1;
        add_pkt(0, 3, base);
        add_pkt(2, 2, base + 1);
        add_pkt(1, 2, base + 1);
        add_pkt(3, 2, base + 2);
        log_lane.delete(); log_seq.delete(); log_sof.delete();
        repeat (12) step();
        chk(log_lane.size() == 9, "R9", $sformatf("ordered flit count act=%0d exp=9", log_lane.size()));
        for (int k = 0; k < 9; k++)
            if (k < log_lane.size())
                chk(log_lane[k] == exp_b[k], k < 3 ? "R8" : "R9",
                    $sformatf("ordered slot %0d lane act=%0d exp=%0d", k, log_lane[k], exp_b[k]));
        drain();

        // Random traffic with gaps and backpressure, preemption on
        preempt_en = 1'b1;
        gaps = 1;
        base = cyc + 1;
        for (int k = 0; k < 250; k++)
            add_pkt(int'($urandom % LANES), 1 + int'($urandom % 6), base + 2 * k);
        drain();

        // Random traffic, preemption off
        preempt_en = 1'b0;
        base = cyc + 1;
        for (int k = 0; k < 250; k++)
            add_pkt(int'($urandom % LANES), 1 + int'($urandom % 6), base + 2 * k);
        drain();

        summary();
        $finish;
    end

endmodule